// File: doc/BRIEF.md
# Break-Prefixed Packet Serial Transmitter

This block sends short status packets on a single asynchronous serial line. Each packet opens with a break: the line is held low for eleven bit times. The line then returns high for one bit time, and three character frames follow back to back. Each frame has a start bit, eight data bits sent least significant bit first, an odd parity bit and a stop bit.

Two events can start a packet. The first is a read reply: a single-cycle request carries 23 bits of reply data. The second is an interrupt notification, which is accepted only while interrupts are enabled. The top bit of the 24-bit payload tells the receiver which of the two it is getting.

Packets are sent only in the fast-rate mode. While the slow rate is selected, new requests are not accepted. A request that is already pending is held until the fast rate returns. The busy output covers the whole packet, from the first break bit to the end of the last stop bit. No check byte follows the third frame.

Top module: `ubf_tx`

## Requirements
- R1: The first 11 bit times of every packet drive the line low.
- R2: Each of the three frames is a low start bit, then eight data bits LSB first, then a parity bit that makes the count of ones across data and parity odd, then a high stop bit. Frames follow one another with no gap between them.
- R3: Payload bits 23:16 go out in the first frame, 15:8 in the second and 7:0 in the third. In a read reply, payload bits 22:0 equal the `rd_data_i` captured with the request. In an interrupt packet, bits 22:0 are all zero.
- R4: Payload bit 23 is 1 in a read reply and 0 in an interrupt packet.
- R5: An `irq_req_i` pulse seen while `irq_en_i` is 0 is dropped, and no packet results from it.
- R6: A request seen while `baud_sel_i` is 0 (slow rate) is dropped, and no packet starts while `baud_sel_i` is 0.
- R7: When a read request and an interrupt request are pending together, the read reply is sent first. The interrupt stays pending and is sent as the next packet.
- R8: The line is high for exactly one bit time between the break and the first start bit.
- R9: While idle, the line is high and `busy_o` is 0. `busy_o` rises on the clock edge after the edge that registers an accepted request. It then stays high for exactly 45 × CLKS_PER_BIT cycles, and no bits follow the third stop bit.
- R10: A request accepted during a packet stays pending. Its packet starts after one idle clock cycle once the current packet ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_sel_i | input | 1 | 1 selects the fast rate, where packets are allowed; 0 selects the slow rate |
| irq_en_i | input | 1 | Enables acceptance of interrupt requests |
| rd_req_i | input | 1 | Single-cycle read reply request |
| rd_data_i | input | 23 | Read reply data, captured with `rd_req_i` |
| irq_req_i | input | 1 | Single-cycle interrupt event |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a packet is being sent |

## Verification
A read reply and an interrupt notification can become pending in the same clock cycle. They can also overlap when an interrupt arrives while a read reply is still on the line. The bench provokes both cases. It pulses both requests on the same edge, and it raises an interrupt part-way through a read packet. In each case its scoreboard expects two whole packets in order: the reply first, with flag 1 and the captured data, and then an all-zero interrupt packet with flag 0. Each packet must meet the exact busy length.

// File: rtl/ubf_pkg.sv
package ubf_pkg;
  localparam int FRAME_W = 11;  // start + 8 data + parity + stop

  // Character frame, LSB goes out first: start(0), data LSB first, odd parity, stop(1)
  function automatic logic [FRAME_W-1:0] frame_of(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction
endpackage

// File: rtl/ubf_tick.sv
module ubf_tick #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == CNT_W'(CLKS_PER_BIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: bit periods are never shorter than two clocks
  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ubf_arb.sv
module ubf_arb #(
  parameter int N_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   baud_sel_i,
  input  logic                   irq_en_i,
  input  logic                   rd_req_i,
  input  logic [8*N_BYTES-2:0]   rd_data_i,
  input  logic                   irq_req_i,
  input  logic                   busy_i,
  output logic                   start_o,
  output logic [8*N_BYTES-1:0]   payload_o
);
  localparam int PAYLOAD_W = 8 * N_BYTES;

  logic                 rd_pend_q, rd_pend_d;
  logic                 irq_pend_q, irq_pend_d;
  logic [PAYLOAD_W-2:0] rd_hold_q, rd_hold_d;
  logic                 rd_acc, irq_acc, take_rd, take_irq;

  assign rd_acc   = rd_req_i && baud_sel_i;
  assign irq_acc  = irq_req_i && irq_en_i && baud_sel_i;
  assign start_o  = !busy_i && baud_sel_i && (rd_pend_q || irq_pend_q);
  assign take_rd  = start_o && rd_pend_q;
  assign take_irq = start_o && !rd_pend_q;

  // Flag in the top payload bit: 1 = read reply, 0 = interrupt
  assign payload_o = rd_pend_q ? {1'b1, rd_hold_q} : '0;

  always_comb begin
    rd_pend_d  = (rd_pend_q && !take_rd) || rd_acc;
    irq_pend_d = (irq_pend_q && !take_irq) || irq_acc;
    rd_hold_d  = rd_acc ? rd_data_i : rd_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      irq_pend_q <= 1'b0;
      rd_hold_q  <= '0;
    end else begin
      rd_pend_q  <= rd_pend_d;
      irq_pend_q <= irq_pend_d;
      rd_hold_q  <= rd_hold_d;
    end
  end

  // R7: a read reply that wins the grant leaves the interrupt pending
  p_rd_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && rd_pend_q && irq_pend_q) |=> irq_pend_q);
  // R5: a disabled interrupt cannot become pending
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pend_q && !irq_en_i) |=> !irq_pend_q);
  // R6: slow rate accepts no read request
  p_slow_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pend_q && !baud_sel_i) |=> !rd_pend_q);
endmodule

// File: rtl/ubf_shift.sv
module ubf_shift
  import ubf_pkg::*;
#(
  parameter int N_BYTES    = 3,
  parameter int BREAK_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [8*N_BYTES-1:0] payload_i,
  input  logic                 tick_i,
  output logic                 busy_o,
  output logic                 tx_o
);
  localparam int PAYLOAD_W = 8 * N_BYTES;
  localparam int HDR_BITS  = BREAK_BITS + 1;
  localparam int PKT_BITS  = HDR_BITS + FRAME_W * N_BYTES;
  localparam int IDX_W     = $clog2(PKT_BITS);

  logic [PKT_BITS-1:0] load_vec, sh_q, sh_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                busy_q, busy_d;

  assign load_vec[HDR_BITS-1:0] = {1'b1, {BREAK_BITS{1'b0}}};

  for (genvar j = 0; j < N_BYTES; j++) begin : g_frame
    assign load_vec[HDR_BITS + FRAME_W*j +: FRAME_W] =
      frame_of(payload_i[PAYLOAD_W-1-8*j -: 8]);
  end

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (start_i && !busy_q) begin
      sh_d   = load_vec;
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q && tick_i) begin
      if (idx_q == IDX_W'(PKT_BITS - 1)) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[PKT_BITS-1:1]};
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;

  // R1: break bits are low
  p_break_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(idx_q) < BREAK_BITS) |-> !tx_o);
  // R8: one high bit between break and first frame
  p_gap_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(idx_q) == BREAK_BITS) |-> tx_o);
  // R2: start bits low, stop bits high
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(idx_q) >= HDR_BITS && (int'(idx_q) - HDR_BITS) % FRAME_W == 0) |-> !tx_o);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(idx_q) >= HDR_BITS && (int'(idx_q) - HDR_BITS) % FRAME_W == FRAME_W - 1) |-> tx_o);
  // R9: a packet ends only after its last bit
  p_full_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(idx_q) == IDX_W'(PKT_BITS - 1)));
endmodule

// File: rtl/ubf_tx.sv
module ubf_tx #(
  parameter int CLKS_PER_BIT = 16,
  parameter int N_BYTES      = 3,
  parameter int BREAK_BITS   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_sel_i,
  input  logic                 irq_en_i,
  input  logic                 rd_req_i,
  input  logic [8*N_BYTES-2:0] rd_data_i,
  input  logic                 irq_req_i,
  output logic                 tx_o,
  output logic                 busy_o
);
  localparam int PAYLOAD_W = 8 * N_BYTES;

  logic                 rst_meta_q, rst_sync_q;
  logic                 start, tick, busy;
  logic [PAYLOAD_W-1:0] payload;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ubf_arb #(.N_BYTES(N_BYTES)) u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .baud_sel_i (baud_sel_i),
    .irq_en_i   (irq_en_i),
    .rd_req_i   (rd_req_i),
    .rd_data_i  (rd_data_i),
    .irq_req_i  (irq_req_i),
    .busy_i     (busy),
    .start_o    (start),
    .payload_o  (payload)
  );

  ubf_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (busy),
    .tick_o (tick)
  );

  ubf_shift #(.N_BYTES(N_BYTES), .BREAK_BITS(BREAK_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start),
    .payload_i (payload),
    .tick_i    (tick),
    .busy_o    (busy),
    .tx_o      (tx_o)
  );

  assign busy_o = busy;

  // R6: every packet start follows a cycle with the fast rate selected
  p_fast_only_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy_o) |-> $past(baud_sel_i));
endmodule

// File: tb/test_ubf_tx.sv
`timescale 1ns/1ps
module test_ubf_tx;
  localparam int CPB = 8;
  localparam int PKT = 45;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_sel = 1'b1;
  logic        irq_en = 1'b0;
  logic        rd_req = 1'b0;
  logic [22:0] rd_data = '0;
  logic        irq_req = 1'b0;
  logic        tx_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [PKT-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  ubf_tx #(.CLKS_PER_BIT(CPB)) i_ubf_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_sel_i (baud_sel),
    .irq_en_i   (irq_en),
    .rd_req_i   (rd_req),
    .rd_data_i  (rd_data),
    .irq_req_i  (irq_req),
    .tx_o       (tx_o),
    .busy_o     (busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected line bits in send order, built from R1 R2 R3 R4 R8
  function automatic logic [PKT-1:0] pkt_bits(input logic is_rd, input logic [22:0] d);
    logic [23:0]    p;
    logic [PKT-1:0] v;
    logic [7:0]     b;
    v = '0;
    p = is_rd ? {1'b1, d} : 24'h0;
    v[11] = 1'b1;
    for (int j = 0; j < 3; j++) begin
      b = p[23 - 8*j -: 8];
      v[12 + 11*j] = 1'b0;
      for (int i = 0; i < 8; i++) v[12 + 11*j + 1 + i] = b[i];
      v[12 + 11*j + 9]  = ~^b;
      v[12 + 11*j + 10] = 1'b1;
    end
    return v;
  endfunction

  task automatic do_read(input logic [22:0] d);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_data = d;
    if (baud_sel) exp_q.push_back(pkt_bits(1'b1, d));
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_irq();
    @(negedge clk);
    irq_req = 1'b1;
    if (baud_sel && irq_en) exp_q.push_back(pkt_bits(1'b0, '0));
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic do_both(input logic [22:0] d);
    @(negedge clk);
    rd_req  = 1'b1;
    irq_req = 1'b1;
    rd_data = d;
    exp_q.push_back(pkt_bits(1'b1, d));   // R7: reply first
    exp_q.push_back(pkt_bits(1'b0, '0));
    @(negedge clk);
    rd_req  = 1'b0;
    irq_req = 1'b0;
  endtask

  task automatic wait_pkts(input int n);
    repeat (n * (PKT * CPB + 2) + 6) @(negedge clk);
  endtask

  // Monitor: samples each bit at mid-period and checks the busy length
  initial begin
    logic [PKT-1:0] got, e;
    forever begin
      @(negedge clk);
      if (rst_n && busy_o === 1'b1) begin
        got = '0;
        for (int n = 0; n <= PKT * CPB; n++) begin
          if (n > 0) @(negedge clk);
          if (n % CPB == CPB / 2 && n / CPB < PKT) got[n / CPB] = tx_o;
          if (n == PKT * CPB - 1) chk(busy_o === 1'b1, "R9 busy held to last stop bit", busy_o, 1);
          if (n == PKT * CPB)     chk(busy_o === 1'b0, "R9 busy drops after last stop bit", busy_o, 0);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 R6 unexpected packet", got, 0);
        end else begin
          e = exp_q.pop_front();
          chk(got === e, "R1 R2 R3 R4 R8 packet bits", got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_o === 1'b1 && busy_o === 1'b0, "R9 idle line after reset", {busy_o, tx_o}, 2'b01);

    do_read(23'h35A3C1);  wait_pkts(1);
    do_read(23'h7FFFFF);  wait_pkts(1);
    do_read(23'h000000);  wait_pkts(1);

    irq_en = 1'b1;
    do_irq();             wait_pkts(1);

    irq_en = 1'b0;
    do_irq();
    repeat (30) @(negedge clk);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R5 disabled interrupt ignored", {busy_o, tx_o}, 2'b01);

    irq_en   = 1'b1;
    baud_sel = 1'b0;
    do_read(23'h123456);
    do_irq();
    repeat (30) @(negedge clk);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R6 slow rate sends nothing", {busy_o, tx_o}, 2'b01);
    baud_sel = 1'b1;
    repeat (30) @(negedge clk);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R6 slow-rate requests dropped", {busy_o, tx_o}, 2'b01);

    do_both(23'h2AAAAA);  wait_pkts(2);   // R7

    do_read(23'h0F0F0F);                  // R10: interrupt arrives mid-packet
    repeat (100) @(negedge clk);
    chk(busy_o === 1'b1, "R10 packet in progress", busy_o, 1);
    do_irq();
    wait_pkts(2);

    chk(exp_q.size() == 0, "R7 R10 all expected packets seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule